// File: doc/BRIEF.md
# Reaction Match Game Core

This block is the core of a reaction-timing game. Two small counters run from one clock in opposite directions. One climbs and the other falls, and each is kept inside the range 1 to 5 by reload logic. The range holds five values, an odd count. Because of that, the two sequences are not equal on every pass. They meet only at the middle value 3, once in every five running cycles.

A player holds a halt input low to let the counters run and raises it to freeze them. While halted, the block reports a win when the two frozen values are equal and a loss when they differ. While running, it reports neither. Display drivers, button conditioning and speed selection sit outside this block.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `rxg_match_core`

## Requirements
- R1: While reset is applied, and from the moment it is asserted, the rising count is 1 and the falling count is 5.
- R2: On each clock edge where halt_i is sampled low, the rising count steps up by one, and a value of 5 reloads to 1.
- R3: On each clock edge where halt_i is sampled low, the falling count steps down by one, and a value of 1 reloads to 5.
- R4: On each clock edge where halt_i is sampled high, both counts keep their values, including when they sit at the reload values 5 and 1.
- R5: While halt_i is high and the two counts are equal, win_o is 1 and lose_o is 0.
- R6: While halt_i is high and the two counts differ, lose_o is 1 and win_o is 0.
- R7: While halt_i is low, win_o and lose_o are both 0.
- R8: Both counts always stay within 1 to 5, and their sum is always 6, so they are equal only at value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| halt_i | input | 1 | 1 freezes both counters and shows the verdict; 0 lets them run |
| up_cnt_o | output | 3 | Rising count (1 to 5) |
| dn_cnt_o | output | 3 | Falling count (5 to 1) |
| win_o | output | 1 | Halted with equal counts |
| lose_o | output | 1 | Halted with different counts |

## Verification
The bench first runs a directed pattern: halt held high straight after reset, which must show a loss at 1 and 5 without moving. It then runs exactly two cycles and halts, which must land on the only matching value and show a win. A long uninterrupted run crosses both reload points several times, which separates a correct wrap from an off-by-one range. Random halt patterns then freeze the counters at every phase of the cycle, including right on a reload value, which tells a frozen counter apart from one that still reloads. A reset asserted in the middle of a run checks that the counters return to their start values at once.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int unsigned CNT_W = 3;
  localparam logic [CNT_W-1:0] RANGE_LO = 3'd1;
  localparam logic [CNT_W-1:0] RANGE_HI = 3'd5;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/rxg_rst_sync.sv
module rxg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/rxg_counter.sv
module rxg_counter
  import rxg_pkg::*;
#(
  parameter int unsigned       W         = CNT_W,
  parameter logic [W-1:0]      RST_VAL   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  dir_e         dir_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] STEP = 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  // Load only acts while enabled; load wins over stepping.
  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (load_i) begin
        cnt_d = load_val_i;
      end else if (dir_i == DIR_UP) begin
        cnt_d = cnt_q + STEP;
      end else begin
        cnt_d = cnt_q - STEP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_VAL;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R4: a disabled counter never moves, even with load pending
  assert_hold_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));

  // R2 R3: an enabled load takes the presented value on the next edge
  assert_load_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/rxg_wrap_ctrl.sv
module rxg_wrap_ctrl
  import rxg_pkg::*;
#(
  parameter int unsigned  W        = CNT_W,
  parameter logic [W-1:0] WATCH    = RANGE_HI,
  parameter logic [W-1:0] RELOAD   = RANGE_LO
) (
  input  logic [W-1:0] cnt_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o
);
  always_comb begin
    load_o     = (cnt_i == WATCH);
    load_val_o = RELOAD;
  end
endmodule

// File: rtl/rxg_verdict.sv
module rxg_verdict
  import rxg_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         halt_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         win_o,
  output logic         lose_o
);
  logic same;

  always_comb begin
    same   = (a_i == b_i);
    win_o  = halt_i & same;
    lose_o = halt_i & ~same;
  end

  // R8: never both results at once
  assert_one_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_o && lose_o));

  // R5 R6: while halted exactly one result shows
  assert_halt_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> $countones({win_o, lose_o}) == 1);
endmodule

// File: rtl/rxg_match_core.sv
module rxg_match_core
  import rxg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  output logic [CNT_W-1:0] up_cnt_o,
  output logic [CNT_W-1:0] dn_cnt_o,
  output logic             win_o,
  output logic             lose_o
);
  localparam logic [CNT_W-1:0] SUM = RANGE_LO + RANGE_HI;

  logic             rst_sync_n;
  logic             run_en;
  logic [CNT_W-1:0] up_cnt, dn_cnt;
  logic             up_load, dn_load;
  logic [CNT_W-1:0] up_ld_val, dn_ld_val;

  rxg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  always_comb begin
    run_en = ~halt_i;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == 0) begin : g_up
      rxg_wrap_ctrl #(.W(CNT_W), .WATCH(RANGE_HI), .RELOAD(RANGE_LO)) u_ctrl (
        .cnt_i(up_cnt), .load_o(up_load), .load_val_o(up_ld_val)
      );
      rxg_counter #(.W(CNT_W), .RST_VAL(RANGE_LO)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(run_en), .dir_i(DIR_UP),
        .load_i(up_load), .load_val_i(up_ld_val), .cnt_o(up_cnt)
      );
    end else begin : g_dn
      rxg_wrap_ctrl #(.W(CNT_W), .WATCH(RANGE_LO), .RELOAD(RANGE_HI)) u_ctrl (
        .cnt_i(dn_cnt), .load_o(dn_load), .load_val_o(dn_ld_val)
      );
      rxg_counter #(.W(CNT_W), .RST_VAL(RANGE_HI)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(run_en), .dir_i(DIR_DOWN),
        .load_i(dn_load), .load_val_i(dn_ld_val), .cnt_o(dn_cnt)
      );
    end
  end

  rxg_verdict #(.W(CNT_W)) u_verdict (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .halt_i(halt_i),
    .a_i   (up_cnt),
    .b_i   (dn_cnt),
    .win_o (win_o),
    .lose_o(lose_o)
  );

  assign up_cnt_o = up_cnt;
  assign dn_cnt_o = dn_cnt;

  // R8: both counts stay in range
  assert_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (up_cnt >= RANGE_LO) && (up_cnt <= RANGE_HI) &&
    (dn_cnt >= RANGE_LO) && (dn_cnt <= RANGE_HI));

  // R8: the two counts mirror each other around the middle value
  assert_mirror_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (up_cnt + dn_cnt) == SUM);

  // R2: rising count wraps from top to bottom while running
  assert_up_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!halt_i && up_cnt == RANGE_HI) |=> (up_cnt == RANGE_LO));

  // R3: falling count wraps from bottom to top while running
  assert_dn_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!halt_i && dn_cnt == RANGE_LO) |=> (dn_cnt == RANGE_HI));

  // R7: no result while running
  assert_quiet_run_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !halt_i |-> (!win_o && !lose_o));

  // R5: a win only shows on equal counts
  assert_win_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    win_o |-> (up_cnt == dn_cnt));
endmodule

// File: tb/rxg_match_core_tb_top.sv
module rxg_match_core_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       halt_i;
  logic [2:0] up_cnt_o, dn_cnt_o;
  logic       win_o, lose_o;

  int checks = 0;
  int fails  = 0;
  int exp_up, exp_dn;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  rxg_match_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i),
    .up_cnt_o(up_cnt_o), .dn_cnt_o(dn_cnt_o), .win_o(win_o), .lose_o(lose_o)
  );

  function automatic int nxt_up(int v);
    return (v == 5) ? 1 : v + 1;
  endfunction

  function automatic int nxt_dn(int v);
    return (v == 1) ? 5 : v - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(bit h);
    chk(h ? "R4 up" : "R2 up", up_cnt_o, exp_up);
    chk(h ? "R4 dn" : "R3 dn", dn_cnt_o, exp_dn);
    if (!h) begin
      chk("R7 win", win_o, 0);
      chk("R7 lose", lose_o, 0);
    end else if (exp_up == exp_dn) begin
      chk("R5 win", win_o, 1);
      chk("R5 lose", lose_o, 0);
    end else begin
      chk("R6 win", win_o, 0);
      chk("R6 lose", lose_o, 1);
    end
    chk("R8 sum", up_cnt_o + dn_cnt_o, 6);
  endtask

  // drive at negedge, model the posedge, check at next negedge
  task automatic step(bit h);
    halt_i = h;
    @(posedge clk_i);
    if (!h) begin
      exp_up = nxt_up(exp_up);
      exp_dn = nxt_dn(exp_dn);
    end
    @(negedge clk_i);
    check_all(h);
  endtask

  task automatic do_reset();
    halt_i = 1'b1;
    rst_ni = 1'b0;
    exp_up = 1;
    exp_dn = 5;
    #1;
    chk("R1 up", up_cnt_o, 1);
    chk("R1 dn", dn_cnt_o, 5);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    halt_i = 1'b1;
    rst_ni = 1'b0;
    @(negedge clk_i);
    do_reset();
    // R6 at reset values 1 and 5
    chk("R6 lose at reset", lose_o, 1);
    // run two cycles to land on 3/3, then halt: R5
    step(1'b0);
    step(1'b0);
    step(1'b1);
    chk("R5 match at 3", win_o, 1);
    // long run across both wrap points
    for (int i = 0; i < 12; i++) step(1'b0);
    // freeze exactly on reload values: up=5 dn=1
    while (exp_up != 5) step(1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);
    chk("R4 frozen at top", up_cnt_o, 5);
    step(1'b0);
    chk("R2 wrap to 1", up_cnt_o, 1);
    chk("R3 wrap to 5", dn_cnt_o, 5);
    // random halt pattern
    for (int i = 0; i < 600; i++) step(($urandom % 3) == 0);
    // reset in the middle of a run
    step(1'b0);
    step(1'b0);
    @(negedge clk_i);
    do_reset();
    for (int i = 0; i < 200; i++) step(($urandom % 2) == 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule